// File: doc/BRIEF.md
# Node Memory Controller with Atomic Fetch-and-Op

This controller sits in one processor-memory node of a shared-memory multiprocessor. It has two requesters: the node's own port, which the processor and the I/O support port share and which is served identically for both, and a port that carries requests arriving from the interconnect switch. Each request from the node's own port is steered by the node-number field in the upper bits of its word address. When that field matches the node's ID the request is served from the local memory module. Otherwise it is passed to the switch, and the switch's reply is returned as the result.

Plain reads, byte-masked writes and three atomic operations (fetch-and-add, fetch-and-or, fetch-and-and) are executed against the local module. An atomic returns the word as it was before the update. Its memory read and its memory write occupy consecutive memory cycles while the controller is locked, so colliding atomics are serialized and never merged. The controller holds at most one request in flight. When both ports request in the same cycle, the grant alternates between them.

Top module: `node_memctl`

## Requirements
- R1: A request on the local port whose address bits [15:7] (node field) differ from `node_id` never touches memory. It is presented on the `sw_req_*` outputs for exactly one cycle with its opcode, address, data and byte enables unchanged. Its response on the local port carries `sw_rsp_data` from the cycle in which `sw_rsp_valid` is high.
- R2: Opcode 0 (read) of a local word at offset bits [6:0] returns that word. The response is valid 2 clock edges after the accepting edge. Opcodes 5 to 7 behave as reads.
- R3: Opcode 1 (write) updates only the bytes whose bit is set in the 4-bit byte enable, where bit i covers data bits [8i+7:8i]. It responds 1 edge after the accepting edge.
- R4: Opcode 2 (fetch-and-add) returns the old word and stores the old word plus the operand, modulo 2^32.
- R5: Opcode 3 (fetch-or) and opcode 4 (fetch-and) return the old word and store the old word OR or AND the operand. All byte enables are ignored for atomics.
- R6: An atomic responds 2 edges after its accepting edge. Its memory read is followed in the next cycle by its memory write, and no second memory read occurs in between.
- R7: Requests on the remote port always use the local module, addressed by offset bits [6:0], with the node field ignored. Their response appears only on the remote response port, and they cause no switch traffic.
- R8: When both ports request in the same idle cycle, the port not granted last is accepted. After reset, the local port wins the first collision. At most one `*_ready` is high in any cycle.
- R9: After a request is accepted, neither ready is raised again until its response cycle has passed.
- R10: After reset, the block raises no ready without a request, no response, no memory enable and no switch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 9 | This node's number |
| lq_valid | input | 1 | Local-port request valid |
| lq_ready | output | 1 | Local-port request accepted this cycle |
| lq_op | input | 3 | Local-port opcode |
| lq_addr | input | 16 | Local-port word address (node field plus offset) |
| lq_wdata | input | 32 | Local-port write data or atomic operand |
| lq_be | input | 4 | Local-port byte enables |
| lq_rsp_valid | output | 1 | Local-port response valid |
| lq_rsp_data | output | 32 | Local-port response data |
| rq_valid | input | 1 | Remote-port request valid |
| rq_ready | output | 1 | Remote-port request accepted this cycle |
| rq_op | input | 3 | Remote-port opcode |
| rq_addr | input | 16 | Remote-port word address |
| rq_wdata | input | 32 | Remote-port write data or operand |
| rq_be | input | 4 | Remote-port byte enables |
| rq_rsp_valid | output | 1 | Remote-port response valid |
| rq_rsp_data | output | 32 | Remote-port response data |
| sw_req_valid | output | 1 | Request to switch valid |
| sw_req_op | output | 3 | Opcode to switch |
| sw_req_addr | output | 16 | Address to switch |
| sw_req_wdata | output | 32 | Data to switch |
| sw_req_be | output | 4 | Byte enables to switch |
| sw_rsp_valid | input | 1 | Reply from switch valid |
| sw_rsp_data | input | 32 | Reply data from switch |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 7 | Memory word index |
| mem_be | output | 4 | Memory byte write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |

## Verification
All three atomic opcodes are swept over eight words with distinct operands, and each is followed by a read-back. This separates the returned old value from the stored new value and catches an opcode applied to the wrong function, including an add that wraps past 2^32. Every one of the 16 byte-enable masks is written over a zeroed word, which exposes a lane that is swapped or stuck. Addresses with a matching node field, a non-matching one, and remote-port addresses carrying an arbitrary node field are compared against each other to confirm steering. Collisions are driven with both ports held valid across several grants, which shows the alternation and the lock-out while a request is in flight.

// File: rtl/node_memctl.sv
module node_memctl #(
  parameter int NODE_W = 9,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODE_W-1:0]        node_id,
  input  logic                     lq_valid,
  output logic                     lq_ready,
  input  logic [2:0]               lq_op,
  input  logic [ADDR_W-1:0]        lq_addr,
  input  logic [DATA_W-1:0]        lq_wdata,
  input  logic [DATA_W/8-1:0]      lq_be,
  output logic                     lq_rsp_valid,
  output logic [DATA_W-1:0]        lq_rsp_data,
  input  logic                     rq_valid,
  output logic                     rq_ready,
  input  logic [2:0]               rq_op,
  input  logic [ADDR_W-1:0]        rq_addr,
  input  logic [DATA_W-1:0]        rq_wdata,
  input  logic [DATA_W/8-1:0]      rq_be,
  output logic                     rq_rsp_valid,
  output logic [DATA_W-1:0]        rq_rsp_data,
  output logic                     sw_req_valid,
  output logic [2:0]               sw_req_op,
  output logic [ADDR_W-1:0]        sw_req_addr,
  output logic [DATA_W-1:0]        sw_req_wdata,
  output logic [DATA_W/8-1:0]      sw_req_be,
  input  logic                     sw_rsp_valid,
  input  logic [DATA_W-1:0]        sw_rsp_data,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [ADDR_W-NODE_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0]      mem_be,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata
);
  localparam int LOC_W = ADDR_W - NODE_W;
  localparam int BE_W  = DATA_W / 8;
  localparam logic [2:0] OP_WR = 3'd1, OP_ADD = 3'd2, OP_OR = 3'd3, OP_AND = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_MRD, S_RDW, S_MWR, S_SWS, S_SWW, S_RSP} state_t;

  state_t            st;
  logic              last_rem, src_rem;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rsp_q, upd;
  logic [BE_W-1:0]   be_q;

  wire idle     = (st == S_IDLE);
  wire pick_rem = rq_valid && (!lq_valid || !last_rem);
  assign rq_ready = idle && pick_rem;
  assign lq_ready = idle && lq_valid && !pick_rem;
  wire accept   = lq_ready || rq_ready;

  wire [2:0]        op_s   = pick_rem ? rq_op    : lq_op;
  wire [ADDR_W-1:0] addr_s = pick_rem ? rq_addr  : lq_addr;
  wire [DATA_W-1:0] data_s = pick_rem ? rq_wdata : lq_wdata;
  wire [BE_W-1:0]   be_s   = pick_rem ? rq_be    : lq_be;
  wire to_switch = !pick_rem && (lq_addr[ADDR_W-1 -: NODE_W] != node_id);
  wire atomic    = (op_q == OP_ADD) || (op_q == OP_OR) || (op_q == OP_AND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      last_rem <= 1'b1;
      src_rem  <= 1'b0;
      op_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rsp_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q     <= op_s;
          addr_q   <= addr_s;
          wdata_q  <= data_s;
          be_q     <= be_s;
          src_rem  <= pick_rem;
          last_rem <= pick_rem;
          st <= to_switch ? S_SWS : (op_s == OP_WR ? S_MWR : S_MRD);
        end
        S_MRD: st <= S_RDW;
        S_RDW: begin
          rsp_q <= mem_rdata;
          st    <= S_RSP;
        end
        S_MWR: begin
          rsp_q <= '0;
          st    <= S_RSP;
        end
        S_SWS: st <= S_SWW;
        S_SWW: if (sw_rsp_valid) begin
          rsp_q <= sw_rsp_data;
          st    <= S_RSP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (op_q)
      OP_ADD:  upd = mem_rdata + wdata_q;
      OP_OR:   upd = mem_rdata | wdata_q;
      OP_AND:  upd = mem_rdata & wdata_q;
      default: upd = mem_rdata;
    endcase
  end

  assign mem_en    = (st == S_MRD) || (st == S_MWR) || (st == S_RDW && atomic);
  assign mem_we    = (st == S_MWR) || (st == S_RDW);
  assign mem_addr  = addr_q[LOC_W-1:0];
  assign mem_be    = (st == S_MWR) ? be_q : {BE_W{1'b1}};
  assign mem_wdata = (st == S_RDW) ? upd : wdata_q;

  assign sw_req_valid = (st == S_SWS);
  assign sw_req_op    = op_q;
  assign sw_req_addr  = addr_q;
  assign sw_req_wdata = wdata_q;
  assign sw_req_be    = be_q;

  assign lq_rsp_valid = (st == S_RSP) && !src_rem;
  assign rq_rsp_valid = (st == S_RSP) && src_rem;
  assign lq_rsp_data  = rsp_q;
  assign rq_rsp_data  = rsp_q;
endmodule

// File: rtl/node_memctl_chk.sv
module node_memctl_chk #(
  parameter int NODE_W = 9,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODE_W-1:0] node_id,
  input logic              lq_valid,
  input logic              lq_ready,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic              lq_rsp_valid,
  input logic              rq_rsp_valid,
  input logic              sw_req_valid,
  input logic [ADDR_W-1:0] sw_req_addr,
  input logic              mem_en,
  input logic              mem_we
);
  logic busy, last_rem;
  wire acc = lq_ready || rq_ready;
  wire rsp = lq_rsp_valid || rq_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      last_rem <= 1'b1;
    end else begin
      if (acc) begin
        busy     <= 1'b1;
        last_rem <= rq_ready;
      end else if (rsp) begin
        busy <= 1'b0;
      end
    end
  end

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !busy);
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lq_ready, rq_ready}));
  assert_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_valid && rq_valid && acc) |-> (rq_ready == !last_rem));
  assert_switch_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_valid |-> (sw_req_addr[ADDR_W-1 -: NODE_W] != node_id));
  assert_switch_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_valid |-> !mem_en);
  assert_no_double_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> !(mem_en && !mem_we));
  assert_one_rsp_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lq_rsp_valid && rq_rsp_valid));
endmodule

bind node_memctl node_memctl_chk #(.NODE_W(NODE_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_node_memctl.sv
module tb_node_memctl;
  logic clk = 0, rst_n = 0;
  logic [8:0] node_id = 9'h05A;
  logic lq_valid = 0, rq_valid = 0, lq_ready, rq_ready;
  logic [2:0] lq_op = 0, rq_op = 0, sw_req_op;
  logic [15:0] lq_addr = 0, rq_addr = 0, sw_req_addr;
  logic [31:0] lq_wdata = 0, rq_wdata = 0, sw_req_wdata, sw_rsp_data = 0;
  logic [3:0] lq_be = 0, rq_be = 0, sw_req_be, mem_be;
  logic lq_rsp_valid, rq_rsp_valid, sw_req_valid, sw_rsp_valid = 0, mem_en, mem_we;
  logic [31:0] lq_rsp_data, rq_rsp_data, mem_wdata, mem_rdata;
  logic [6:0] mem_addr;

  always #10 clk = ~clk;

  node_memctl dut (.*);

  logic [31:0] mem [128];
  logic [31:0] shadow [128];
  always @(posedge clk) if (mem_en) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else mem_rdata <= mem[mem_addr];
  end

  int sw_count = 0;
  logic [2:0] sw_op_seen; logic [15:0] sw_addr_seen; logic [31:0] sw_data_seen; logic [3:0] sw_be_seen;
  initial forever begin
    @(negedge clk);
    if (sw_req_valid) begin
      sw_count++;
      sw_op_seen = sw_req_op; sw_addr_seen = sw_req_addr;
      sw_data_seen = sw_req_wdata; sw_be_seen = sw_req_be;
      repeat (3) @(negedge clk);
      sw_rsp_valid = 1; sw_rsp_data = {16'h0, sw_req_addr} * 3 + sw_data_seen;
      @(negedge clk);
      sw_rsp_valid = 0;
    end
  end

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit rem, input logic [2:0] op, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [3:0] be,
                        output logic [31:0] rd, output int lat);
    int w;
    @(negedge clk);
    if (rem) begin rq_valid = 1; rq_op = op; rq_addr = addr; rq_wdata = wd; rq_be = be; end
    else     begin lq_valid = 1; lq_op = op; lq_addr = addr; lq_wdata = wd; lq_be = be; end
    #1;
    w = 0;
    while (!(rem ? rq_ready : lq_ready) && w < 50) begin @(negedge clk); #1; w++; end
    @(posedge clk);
    @(negedge clk);
    rq_valid = 0; lq_valid = 0;
    lat = 0;
    while (!(rem ? rq_rsp_valid : lq_rsp_valid) && lat < 50) begin @(negedge clk); lat++; end
    rd = rem ? rq_rsp_data : lq_rsp_data;
  endtask

  function automatic logic [31:0] apply(input logic [2:0] op, input logic [31:0] o, input logic [31:0] v);
    case (op)
      3'd2: return o + v;
      3'd3: return o | v;
      default: return o & v;
    endcase
  endfunction

  bit done = 0;
  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd, ex, old;
    int lat, sc, ok_r9;
    for (int i = 0; i < 128; i++) begin mem[i] = 0; shadow[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!lq_ready && !rq_ready && !lq_rsp_valid && !rq_rsp_valid && !mem_en && !sw_req_valid,
        "R10 reset idle", {26'h0, lq_ready, rq_ready, lq_rsp_valid, rq_rsp_valid, mem_en, sw_req_valid}, 0);

    // R3 full-word writes, R2 read back
    for (int i = 0; i < 16; i++) begin
      ex = i * 32'h01010101 ^ 32'hA5A50000;
      do_req(0, 3'd1, {node_id, 7'(i)}, ex, 4'hF, rd, lat);
      shadow[i] = ex;
      chk(lat == 1, "R3 write latency", lat, 1);
    end
    for (int i = 0; i < 16; i++) begin
      do_req(0, (i % 4 == 3) ? 3'd6 : 3'd0, {node_id, 7'(i)}, 0, 0, rd, lat);
      chk(rd == shadow[i] && lat == 2, "R2 read data/latency", rd, shadow[i]);
    end

    // R3 byte-enable sweep
    for (int be = 0; be < 16; be++) begin
      do_req(0, 3'd1, {node_id, 7'(32 + be)}, 0, 4'hF, rd, lat);
      do_req(0, 3'd1, {node_id, 7'(32 + be)}, 32'hFFFFFFFF, 4'(be), rd, lat);
      ex = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      shadow[32 + be] = ex;
      do_req(0, 3'd0, {node_id, 7'(32 + be)}, 0, 0, rd, lat);
      chk(rd == ex, "R3 byte enables", rd, ex);
    end

    // R4 R5 R6 atomic sweep
    for (int op = 2; op <= 4; op++) begin
      for (int a = 0; a < 8; a++) begin
        ex = op * 32'h1357 + a * 32'h9E3779B9;
        old = shadow[a];
        do_req(0, 3'(op), {node_id, 7'(a)}, ex, 4'h0, rd, lat);
        chk(rd == old, op == 2 ? "R4 fetch-add old" : "R5 fetch-or/and old", rd, old);
        chk(lat == 2, "R6 atomic latency", lat, 2);
        shadow[a] = apply(3'(op), old, ex);
        do_req(0, 3'd0, {node_id, 7'(a)}, 0, 0, rd, lat);
        chk(rd == shadow[a], op == 2 ? "R4 fetch-add new" : "R5 fetch-or/and new", rd, shadow[a]);
      end
    end
    do_req(0, 3'd1, {node_id, 7'd20}, 32'hFFFFFFFF, 4'hF, rd, lat);
    do_req(0, 3'd2, {node_id, 7'd20}, 32'd2, 4'hF, rd, lat);
    chk(rd == 32'hFFFFFFFF, "R4 wrap old", rd, 32'hFFFFFFFF);
    do_req(0, 3'd0, {node_id, 7'd20}, 0, 0, rd, lat);
    chk(rd == 32'd1, "R4 wrap new", rd, 1);
    shadow[20] = 1;

    // R7 remote port
    sc = sw_count;
    do_req(1, 3'd0, {9'h1FF, 7'd3}, 0, 0, rd, lat);
    chk(rd == shadow[3] && lat == 2, "R7 remote read", rd, shadow[3]);
    do_req(1, 3'd2, {9'h003, 7'd4}, 32'h10, 0, rd, lat);
    chk(rd == shadow[4], "R7 remote atomic old", rd, shadow[4]);
    shadow[4] = shadow[4] + 32'h10;
    do_req(0, 3'd0, {node_id, 7'd4}, 0, 0, rd, lat);
    chk(rd == shadow[4], "R7 remote atomic stored", rd, shadow[4]);
    chk(sw_count == sc, "R7 no switch traffic", sw_count, sc);

    // R1 foreign node
    for (int n = 0; n < 3; n++) begin
      logic [15:0] fa;
      fa = {node_id ^ 9'(1 << (n * 4)), 7'd5};
      sc = sw_count;
      do_req(0, 3'(n + 1), fa, 32'h1234 + n, 4'(3 + n), rd, lat);
      ex = {16'h0, fa} * 3 + 32'h1234 + n;
      chk(rd == ex, "R1 switch reply", rd, ex);
      chk(sw_count == sc + 1 && sw_addr_seen == fa && sw_op_seen == 3'(n + 1)
          && sw_data_seen == 32'h1234 + n && sw_be_seen == 4'(3 + n), "R1 switch fields", sw_addr_seen, fa);
    end
    do_req(0, 3'd0, {node_id, 7'd5}, 0, 0, rd, lat);
    chk(rd == shadow[5], "R1 local untouched", rd, shadow[5]);

    // R8 R9 collisions: last grant local -> remote, local, remote
    do_req(0, 3'd0, {node_id, 7'd1}, 0, 0, rd, lat);
    @(negedge clk);
    lq_valid = 1; lq_op = 0; lq_addr = {node_id, 7'd1};
    rq_valid = 1; rq_op = 0; rq_addr = {9'h0, 7'd2};
    #1;
    chk(rq_ready && !lq_ready, "R8 first collision remote", {30'h0, lq_ready, rq_ready}, 1);
    @(posedge clk); @(negedge clk);
    rq_valid = 0;
    ok_r9 = 1; lat = 0;
    while (!rq_rsp_valid && lat < 50) begin
      if (lq_ready) ok_r9 = 0;
      @(negedge clk); lat++;
    end
    chk(rq_rsp_data == shadow[2], "R8 remote data", rq_rsp_data, shadow[2]);
    chk(ok_r9 == 1 && !lq_ready, "R9 locked while busy", ok_r9, 1);
    @(negedge clk); #1;
    chk(lq_ready, "R8 local next", lq_ready, 1);
    @(posedge clk); @(negedge clk);
    rq_valid = 1; rq_addr = {9'h0, 7'd3};
    ok_r9 = 1; lat = 0;
    while (!lq_rsp_valid && lat < 50) begin
      #1; if (rq_ready || lq_ready) ok_r9 = 0;
      @(negedge clk); lat++;
    end
    chk(lq_rsp_data == shadow[1], "R8 local data", lq_rsp_data, shadow[1]);
    chk(ok_r9 == 1, "R9 locked during local", ok_r9, 1);
    @(negedge clk); #1;
    chk(rq_ready && !lq_ready, "R8 alternation remote", {30'h0, lq_ready, rq_ready}, 1);
    @(posedge clk); @(negedge clk);
    rq_valid = 0; lq_valid = 0;
    repeat (8) @(negedge clk);
    summary();
  end
endmodule